// File: doc/BRIEF.md
# Windowed Shift-Register Observation Chain

This block is a long serial shift chain meant for at-speed observation of a logic string. Each rising edge of a fast clock moves every bit one stage down the chain. A fixed, even-length inverter path sits between neighbouring stages and stands in for combinational depth, so a bit keeps its value from stage to stage. The serial input enters the first stage.

The tail of the chain is copied in parallel into a small window register once per window-width of fast clocks. A data clock at the divided rate is driven beside the window. An external capture circuit running only at that slower rate can then latch every bit that leaves the chain, each bit exactly once and in order. The reset input is active low. It is applied asynchronously to a two-flop filter and released synchronously, and the filtered reset clears every register in the block.

Top module: `wsr_obs_chain`

## Requirements
- R1: The chain has CHAIN_LEN stages (default 300). Every stage advances on every rising fast-clock edge, and the serial input is sampled into the first stage on the rising edge.
- R2: Each hop between stages passes through HOP_INV inverters (default 8, which must be even), so the stream leaving the chain equals the stream that entered it, with no inversion.
- R3: The window holds WIN_W bits (default 4). Window bit 0 is the final chain stage and bit WIN_W-1 is the WIN_W-th stage from the end. The window is loaded once every WIN_W fast clocks, so concatenating the window samples, bit 0 first, reproduces the chain output with every bit present exactly once.
- R4: The data clock runs at 1/WIN_W of the fast clock rate. It is high for WIN_W/2 fast clocks and low for WIN_W/2 fast clocks, and it is low while reset is active.
- R5: The window changes only on the fast edge WIN_W/2 cycles after a data-clock rise. It is therefore stable across each rising data-clock edge.
- R6: Reset is active low and asserted asynchronously through the filter. A low pulse on rst_n that spans no clock edge still clears the window, the data clock and the chain.
- R7: Reset release passes through two filter flops. The input bit sampled on the third rising edge after rst_n rises is the first shifted bit. In the window stream, counted from the first data-clock rise after release, that bit stands at position CHAIN_LEN+1 (position 0 is the first bit).
- R8: While reset is active, the chain, the window and the divide counter hold zero and the serial input is ignored. After release the first CHAIN_LEN+1 stream bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast shift clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ser_in | input | 1 | Serial data into the first chain stage |
| win_o | output | WIN_W | Window of the chain tail, bit 0 is the last stage |
| dclk_o | output | 1 | Divided data clock for window capture |

## Verification
The hardest case to reach from the ports is a reset pulse that begins and ends between two clock edges. Only the asynchronous clear of the filter can notice such a pulse. The bench fills the whole chain with ones, then drops rst_n for one nanosecond inside the high phase of the clock. It checks that the window and data clock are zero after the next edge and that the following stream carries no ones. The exact stream position of the first input bit is also checked, which pins down the two-cycle release latency and the window phase together.

// File: rtl/wsr_pkg.sv
// Package: default sizes shared by the observation chain modules.
// Assumes WIN_W is a power of two and HOP_INV is even.
package wsr_pkg;
    localparam int CHAIN_LEN_DEF = 300;
    localparam int HOP_INV_DEF   = 8;
    localparam int WIN_W_DEF     = 4;
endpackage

// File: rtl/wsr_rst_filter.sv
// Module: reset filter. Asserts the internal reset asynchronously when
// rst_n goes low and releases it after two rising clock edges.
// Assumes rst_n may change at any time relative to clk.
module wsr_rst_filter (
    input  logic clk,
    input  logic rst_n,
    output logic srst_n
);
    logic meta_q;
    logic hold_q;

    // Two-flop filter: asynchronous clear, synchronous release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            meta_q <= 1'b1;
            hold_q <= meta_q;
        end
    end

    assign srst_n = hold_q;

    // Internal reset must be low whenever the input reset is low
    always @(negedge clk) begin
        if (rst_n == 1'b0) begin
            // R6
            filt_hold_chk: assert (hold_q == 1'b0)
                else $error("filtered reset released while rst_n low");
        end
    end
endmodule

// File: rtl/wsr_hop_delay.sv
// Module: inter-stage delay. A string of HOP_INV inverters between two
// chain stages. Assumes HOP_INV is even, so the output equals the input.
module wsr_hop_delay #(
    parameter int HOP_INV = 8
) (
    input  logic a_i,
    output logic y_o
);
    logic v;

    // Pass the bit through HOP_INV inversions
    always_comb begin
        v = a_i;
        for (int i = 0; i < HOP_INV; i++) begin
            v = ~v;
        end
    end

    assign y_o = v;
endmodule

// File: rtl/wsr_shift_chain.sv
// Module: the shift chain. CHAIN_LEN flops that all advance on each rising
// edge, with a delay hop between neighbours. The tail is presented in
// window order: tail_o[i] is stage CHAIN_LEN-1-i.
// Assumes a synchronous active-low reset from the filter.
module wsr_shift_chain #(
    parameter int CHAIN_LEN = 300,
    parameter int HOP_INV   = 8,
    parameter int WIN_W     = 4
) (
    input  logic             clk,
    input  logic             srst_n,
    input  logic             ser_in,
    output logic [WIN_W-1:0] tail_o
);
    logic [CHAIN_LEN-1:0] stg_q;
    logic [CHAIN_LEN-1:1] hop_d;

    // One delay hop in front of every stage but the first
    for (genvar g = 1; g < CHAIN_LEN; g++) begin : g_hop
        wsr_hop_delay #(.HOP_INV(HOP_INV)) i_hop (
            .a_i (stg_q[g-1]),
            .y_o (hop_d[g])
        );
    end

    // Shift every stage on each edge, clear on reset
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            stg_q <= '0;
        end else begin
            stg_q[0]             <= ser_in;
            stg_q[CHAIN_LEN-1:1] <= hop_d;
        end
    end

    // Tail bits reordered so index 0 is the last stage
    for (genvar t = 0; t < WIN_W; t++) begin : g_tail
        assign tail_o[t] = stg_q[CHAIN_LEN-1-t];
    end

    // R1
    din_capture_chk: assert property (@(posedge clk) disable iff (!srst_n)
        srst_n |=> stg_q[0] == $past(ser_in));

    // R2
    hop_keep_chk: assert property (@(posedge clk) disable iff (!srst_n)
        srst_n |=> stg_q[CHAIN_LEN-1] == $past(stg_q[CHAIN_LEN-2]));
endmodule

// File: rtl/wsr_window_tap.sv
// Module: window and data clock. A divide-by-WIN_W counter loads the
// chain tail into the window on its terminal count; the counter MSB is the
// data clock, rising WIN_W/2 cycles after each load.
// Assumes WIN_W is a power of two, at least 2.
module wsr_window_tap #(
    parameter int WIN_W = 4
) (
    input  logic             clk,
    input  logic             srst_n,
    input  logic [WIN_W-1:0] tail_i,
    output logic [WIN_W-1:0] win_o,
    output logic             dclk_o
);
    localparam int CW = (WIN_W > 2) ? $clog2(WIN_W) : 1;
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] LAST = CW'(WIN_W - 1);

    logic [CW-1:0]    cnt_q;
    logic [WIN_W-1:0] win_q;

    // Free-running divide counter
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    // Parallel window load on the terminal count
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            win_q <= '0;
        end else if (cnt_q == LAST) begin
            win_q <= tail_i;
        end
    end

    assign win_o  = win_q;
    assign dclk_o = cnt_q[CW-1];

    // R5
    win_phase_chk: assert property (@(posedge clk) disable iff (!srst_n)
        !$stable(win_q) |-> $past(cnt_q) == LAST);

    // R4
    dclk_high_chk: assert property (@(posedge clk) disable iff (!srst_n)
        $rose(dclk_o) |=> dclk_o);

    // R4
    dclk_low_chk: assert property (@(posedge clk) disable iff (!srst_n)
        $fell(dclk_o) |=> !dclk_o);
endmodule

// File: rtl/wsr_obs_chain.sv
// Module: top of the windowed observation chain. Ties the reset filter,
// the shift chain and the window tap together.
// Assumes HOP_INV even and WIN_W a power of two no larger than CHAIN_LEN.
module wsr_obs_chain
    import wsr_pkg::*;
#(
    parameter int CHAIN_LEN = CHAIN_LEN_DEF,
    parameter int HOP_INV   = HOP_INV_DEF,
    parameter int WIN_W     = WIN_W_DEF
) (
    input  logic             clk_fast,
    input  logic             rst_n,
    input  logic             ser_in,
    output logic [WIN_W-1:0] win_o,
    output logic             dclk_o
);
    logic             srst_n;
    logic [WIN_W-1:0] tail;

    wsr_rst_filter i_filt (
        .clk    (clk_fast),
        .rst_n  (rst_n),
        .srst_n (srst_n)
    );

    wsr_shift_chain #(
        .CHAIN_LEN (CHAIN_LEN),
        .HOP_INV   (HOP_INV),
        .WIN_W     (WIN_W)
    ) i_chain (
        .clk    (clk_fast),
        .srst_n (srst_n),
        .ser_in (ser_in),
        .tail_o (tail)
    );

    wsr_window_tap #(.WIN_W(WIN_W)) i_tap (
        .clk    (clk_fast),
        .srst_n (srst_n),
        .tail_i (tail),
        .win_o  (win_o),
        .dclk_o (dclk_o)
    );
endmodule

// File: tb/test_wsr_obs_chain.sv
`timescale 1ns/1ps
// Bench: drives a table of serial patterns through the chain, rebuilds the
// stream from window captures on data-clock rises, then runs reset cases.
module test_wsr_obs_chain;
    localparam int N    = 300;
    localparam int W    = 4;
    localparam int PW   = 16;
    localparam int NPAT = 8;
    localparam int SMAX = 2048;

    // {stimulus word, expected recovered word}; equal because the hop is even (R2)
    localparam logic [2*PW-1:0] VEC [NPAT] = '{
        {16'h0000, 16'h0000},
        {16'hFFFF, 16'hFFFF},
        {16'hAAAA, 16'hAAAA},
        {16'h5555, 16'h5555},
        {16'hF0F0, 16'hF0F0},
        {16'h0F0F, 16'h0F0F},
        {16'h8001, 16'h8001},
        {16'h3C96, 16'h3C96}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_in = 1'b1;
    logic [W-1:0] win;
    logic         dclk;

    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;
    bit           cap_on = 1'b0;
    logic         prev_dclk = 1'b0;
    logic [W-1:0] prev_win = '0;
    int           runlen = 0;
    bit           run_seen = 1'b0;
    logic         sbits [0:SMAX-1];
    int           nbits = 0;

    always #2 clk = ~clk;

    wsr_obs_chain #(.CHAIN_LEN(N), .HOP_INV(8), .WIN_W(W)) i_wsr_obs_chain (
        .clk_fast (clk),
        .rst_n    (rst_n),
        .ser_in   (ser_in),
        .win_o    (win),
        .dclk_o   (dclk)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One fast cycle: sample at the falling edge, record captures, drive next bit
    task automatic step(input logic d);
        @(negedge clk);
        if (cap_on) begin
            if (dclk && !prev_dclk) begin
                check(win == prev_win, "R5 window stable at data clock rise", win, prev_win);
                for (int i = 0; i < W; i++) begin
                    if (nbits < SMAX) begin
                        sbits[nbits] = win[i];
                        nbits++;
                    end
                end
            end
            if (dclk != prev_dclk) begin
                if (run_seen) check(runlen == W/2, "R4 data clock phase length", runlen, W/2);
                run_seen = 1'b1;
                runlen = 1;
            end else begin
                runlen++;
            end
        end
        prev_dclk = dclk;
        prev_win  = win;
        ser_in    = d;
    endtask

    task automatic clear_capture();
        cap_on    = 1'b1;
        prev_dclk = 1'b0;
        prev_win  = win;
        nbits     = 0;
        run_seen  = 1'b0;
        runlen    = 0;
        for (int i = 0; i < SMAX; i++) sbits[i] = 1'bx;
    endtask

    function automatic int ones_in(input int lo, input int hi);
        int c = 0;
        for (int i = lo; i < hi; i++) if (sbits[i] !== 1'b0) c++;
        return c;
    endfunction

    initial begin
        // R8: hold reset with the serial input high; nothing may leave zero
        repeat (6) step(1'b1);
        check(win == '0, "R8 window cleared in reset", win, 0);
        check(dclk == 1'b0, "R4 data clock low in reset", dclk, 0);

        // Release at a falling edge; the bit driven one cycle later is ignored
        @(negedge clk);
        rst_n = 1'b1;
        clear_capture();
        step(1'b0);

        // Table walk: every pattern MSB first, then flush with zeros
        for (int p = 0; p < NPAT; p++) begin
            for (int b = PW - 1; b >= 0; b--) begin
                logic [PW-1:0] stim;
                stim = VEC[p][2*PW-1:PW];
                step(stim[b]);
            end
        end
        repeat (N + 40) step(1'b0);

        // R7 / R8: the first N+1 stream bits are reset zeros
        check(nbits >= N + 1 + NPAT*PW, "R3 enough window captures", nbits, N + 1 + NPAT*PW);
        check(ones_in(0, N + 1) == 0, "R8 leading stream bits zero", ones_in(0, N + 1), 0);

        // R1 R2 R3 R7: each word recovered at its exact stream position
        for (int p = 0; p < NPAT; p++) begin
            logic [PW-1:0] got;
            logic [PW-1:0] exp;
            got = '0;
            exp = VEC[p][PW-1:0];
            for (int j = 0; j < PW; j++) got = {got[PW-2:0], sbits[N + 1 + p*PW + j]};
            check(got === exp, "R3 recovered word in order", got, exp);
        end

        // Fill the whole chain with ones before the short reset pulse
        repeat (N + 8) step(1'b1);
        check(win == '1, "R2 ones reach the window", win, '1);

        // R6: reset pulse that spans no clock edge
        @(posedge clk);
        #0.5 rst_n = 1'b0;
        #1   rst_n = 1'b1;
        clear_capture();
        step(1'b0);
        step(1'b0);
        check(win == '0, "R6 short pulse clears window", win, 0);
        check(dclk == 1'b0, "R6 short pulse holds data clock low", dclk, 0);
        repeat (N + 40) step(1'b0);
        check(nbits >= N + 8, "R3 captures after short pulse", nbits, N + 8);
        check(ones_in(0, nbits) == 0, "R6 chain cleared by short pulse", ones_in(0, nbits), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule